// File: doc/BRIEF.md
# Way-Partitioned Cache Allocation Controller

This block holds the tag and allocation state of a set-associative last-level cache in which each requesting core may only allocate new lines into a restricted group of ways. A small register file keeps one way-enable bitmask per class of service. A second table assigns every core to one class. Lookups compare the tag against every way of the indexed set, whatever the requester's class, so any core can hit on any resident line. On a miss, the controller proposes a victim way drawn only from the ways that the requester's class is allowed to fill.

A lookup presents a core number and an address. One cycle later the block returns hit or miss, the hit way and, on a miss, the proposed victim. The surrounding cache fetches the line and then issues a fill command carrying the address and the way that was returned. The fill writes the tag, marks the way valid and updates replacement state. Reprogramming a class mask or a core's class leaves resident lines untouched. Such a line moves only after it has been evicted and brought back in.

Top module: `cat_alloc_ctrl`

## Requirements
- R1: After reset every class mask is all ones, every core belongs to class 0 and every line is invalid, so any lookup misses and proposes way 0.
- R2: A lookup hits when any valid way of the indexed set holds the tag, even if that way is outside the requester's mask. rsp_way then gives that way.
- R3: On a miss, rsp_hit is 0 and rsp_victim is a way whose bit is set in the mask of the requester's class.
- R4: If a permitted way of the set is invalid, the victim is the lowest-numbered invalid permitted way.
- R5: Each set keeps one used bit per way. With every permitted way valid, the victim is the lowest permitted way whose used bit is clear, or the lowest permitted way if all of them are set. Touching a way sets its bit. When that makes every bit of the set 1, all bits except the touched one are cleared.
- R6: A write of all zeros to a class mask is ignored, and the previous mask stays in force.
- R7: Changing a mask or a core's class neither moves nor invalidates resident lines, and they keep hitting in their original way.
- R8: The set index is lk_addr[OFF_W+SET_W-1:OFF_W] and the tag is the bits above it, for every class. The same tag in a different set does not hit.
- R9: A fill writes the tag of fill_addr into fill_way of its set, sets the valid bit and touches the way for replacement. A hit also touches its way.
- R10: On a configuration write, cfg_sel=0 loads cfg_data into the mask of class cfg_idx. cfg_sel=1 assigns core cfg_idx to class cfg_data[CLS_W-1:0].
- R11: rsp_valid is lk_valid delayed by one cycle. On a hit, rsp_victim is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: class mask, 1: core-to-class entry |
| cfg_idx | input | IDX_W | Class or core index |
| cfg_data | input | NUM_WAYS | Mask value or class number |
| lk_valid | input | 1 | Lookup request |
| lk_core | input | CORE_W | Requesting core |
| lk_addr | input | ADDR_W | Lookup address |
| rsp_valid | output | 1 | Response valid, one cycle after the lookup |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | WAY_W | Way that hit |
| rsp_victim | output | WAY_W | Proposed fill way on a miss |
| fill_valid | input | 1 | Fill command |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_way | input | WAY_W | Way being filled |

## Verification
The assertions assume that the surrounding cache never fills a tag that is already resident in its set, so at most one way can match. They also assume that fill ways lie below NUM_WAYS. The directed stimulus uses a distinct tag for every fill and only fills ways the block has just proposed. With these assumptions the single-match, victim-in-mask and invalid-first properties describe legal traffic only. Lookups and fills are never issued in the same cycle, so the replacement state that each test predicts depends on a single update per cycle.

// File: rtl/cat_pkg.sv
package cat_pkg;

  localparam int MAXW = 32;

  function automatic logic [4:0] first_one(input logic [MAXW-1:0] v);
    logic [4:0] r;
    r = 5'd0;
    for (int i = MAXW - 1; i >= 0; i--) begin
      if (v[i]) r = 5'(i);
    end
    return r;
  endfunction

  function automatic logic [4:0] pick_victim(input logic [MAXW-1:0] allowed,
                                             input logic [MAXW-1:0] valid,
                                             input logic [MAXW-1:0] used);
    logic [MAXW-1:0] empty_ok;
    logic [MAXW-1:0] cold_ok;
    empty_ok = allowed & ~valid;
    cold_ok  = allowed & ~used;
    if (empty_ok != '0)      return first_one(empty_ok);
    else if (cold_ok != '0)  return first_one(cold_ok);
    else                     return first_one(allowed);
  endfunction

  function automatic logic [MAXW-1:0] plru_touch(input logic [MAXW-1:0] used,
                                                 input logic [4:0] way,
                                                 input logic [MAXW-1:0] full);
    logic [MAXW-1:0] nxt;
    logic [MAXW-1:0] one_hot;
    one_hot = MAXW'(1) << way;
    nxt = (used | one_hot) & full;
    if (nxt == full) nxt = one_hot;
    return nxt;
  endfunction

endpackage

// File: rtl/cat_cfg_regs.sv
module cat_cfg_regs #(
  parameter int NUM_WAYS    = 11,
  parameter int NUM_CLASSES = 16,
  parameter int NUM_CORES   = 4,
  parameter int CLS_W       = 4,
  parameter int CORE_W      = 2,
  parameter int IDX_W       = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [NUM_WAYS-1:0] cfg_data,
  input  logic [CORE_W-1:0]   req_core,
  output logic [NUM_WAYS-1:0] req_mask,
  output logic                any_mask_zero
);

  logic [NUM_WAYS-1:0] mask_q  [NUM_CLASSES];
  logic [CLS_W-1:0]    class_q [NUM_CORES];

  logic mask_wr, core_wr;
  assign mask_wr = cfg_we && !cfg_sel && (32'(cfg_idx) < NUM_CLASSES) && (cfg_data != '0);
  assign core_wr = cfg_we &&  cfg_sel && (32'(cfg_idx) < NUM_CORES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CLASSES; c++) mask_q[c] <= '1;
      for (int k = 0; k < NUM_CORES; k++) class_q[k] <= '0;
    end else begin
      if (mask_wr) mask_q[cfg_idx[CLS_W-1:0]] <= cfg_data;
      if (core_wr) class_q[cfg_idx[CORE_W-1:0]] <= cfg_data[CLS_W-1:0];
    end
  end

  assign req_mask = mask_q[class_q[req_core]];

  always_comb begin
    any_mask_zero = 1'b0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (mask_q[c] == '0) any_mask_zero = 1'b1;
    end
  end

endmodule

// File: rtl/cat_tag_store.sv
module cat_tag_store
  import cat_pkg::*;
#(
  parameter int NUM_WAYS = 11,
  parameter int NUM_SETS = 16,
  parameter int SET_W    = 4,
  parameter int TAG_W    = 10,
  parameter int WAY_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_W-1:0]    lk_set,
  input  logic [TAG_W-1:0]    lk_tag,
  output logic [NUM_WAYS-1:0] hit_vec,
  output logic [NUM_WAYS-1:0] set_valid,
  output logic [NUM_WAYS-1:0] set_used,
  input  logic                hit_touch,
  input  logic [WAY_W-1:0]    hit_way,
  input  logic                fill_en,
  input  logic [SET_W-1:0]    fill_set,
  input  logic [TAG_W-1:0]    fill_tag,
  input  logic [WAY_W-1:0]    fill_way
);

  localparam logic [MAXW-1:0] FULL = MAXW'((64'd1 << NUM_WAYS) - 64'd1);

  logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];
  logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
  logic [NUM_WAYS-1:0] used_q  [NUM_SETS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  assign set_valid = valid_q[lk_set];
  assign set_used  = used_q[lk_set];

  logic hit_upd;
  assign hit_upd = hit_touch && !(fill_en && fill_set == lk_set);

  logic [MAXW-1:0] fill_used_nxt, hit_used_nxt;
  assign fill_used_nxt = plru_touch(MAXW'(used_q[fill_set]), 5'(fill_way), FULL);
  assign hit_used_nxt  = plru_touch(MAXW'(used_q[lk_set]), 5'(hit_way), FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        valid_q[s] <= '0;
        used_q[s]  <= '0;
        for (int w = 0; w < NUM_WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      if (fill_en) begin
        tag_q[fill_set][fill_way]   <= fill_tag;
        valid_q[fill_set][fill_way] <= 1'b1;
        used_q[fill_set]            <= fill_used_nxt[NUM_WAYS-1:0];
      end
      if (hit_upd) used_q[lk_set] <= hit_used_nxt[NUM_WAYS-1:0];
    end
  end

endmodule

// File: rtl/cat_alloc_ctrl.sv
module cat_alloc_ctrl
  import cat_pkg::*;
#(
  parameter int NUM_WAYS    = 11,
  parameter int NUM_SETS    = 16,
  parameter int NUM_CLASSES = 16,
  parameter int NUM_CORES   = 4,
  parameter int ADDR_W      = 20,
  parameter int OFF_W       = 6,
  localparam int WAY_W  = $clog2(NUM_WAYS),
  localparam int SET_W  = $clog2(NUM_SETS),
  localparam int CLS_W  = $clog2(NUM_CLASSES),
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W  = (CLS_W > CORE_W) ? CLS_W : CORE_W,
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_sel,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [NUM_WAYS-1:0] cfg_data,
  input  logic                lk_valid,
  input  logic [CORE_W-1:0]   lk_core,
  input  logic [ADDR_W-1:0]   lk_addr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [WAY_W-1:0]    rsp_way,
  output logic [WAY_W-1:0]    rsp_victim,
  input  logic                fill_valid,
  input  logic [ADDR_W-1:0]   fill_addr,
  input  logic [WAY_W-1:0]    fill_way
);

  // Address split, identical for every class.
  logic [SET_W-1:0] lk_set, fill_set;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  assign lk_set   = lk_addr[OFF_W +: SET_W];
  assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
  assign fill_set = fill_addr[OFF_W +: SET_W];
  assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];

  // Named internal events for the checker.
  logic [NUM_WAYS-1:0] lk_mask;
  logic [NUM_WAYS-1:0] hit_vec;
  logic [NUM_WAYS-1:0] set_valid, set_used;
  logic [NUM_WAYS-1:0] inv_vec;
  logic                any_mask_zero;
  logic                any_hit;
  logic [WAY_W-1:0]    hit_way, victim_way;

  cat_cfg_regs #(
    .NUM_WAYS(NUM_WAYS), .NUM_CLASSES(NUM_CLASSES), .NUM_CORES(NUM_CORES),
    .CLS_W(CLS_W), .CORE_W(CORE_W), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .req_core(lk_core),
    .req_mask(lk_mask), .any_mask_zero(any_mask_zero)
  );

  cat_tag_store #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .SET_W(SET_W),
    .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .lk_set(lk_set), .lk_tag(lk_tag),
    .hit_vec(hit_vec), .set_valid(set_valid), .set_used(set_used),
    .hit_touch(lk_valid && any_hit), .hit_way(hit_way),
    .fill_en(fill_valid), .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_way(fill_way)
  );

  logic [4:0] hit_idx5, vic_idx5;
  assign any_hit    = |hit_vec;
  assign inv_vec    = lk_mask & ~set_valid;
  assign hit_idx5   = first_one(MAXW'(hit_vec));
  assign vic_idx5   = pick_victim(MAXW'(lk_mask), MAXW'(set_valid), MAXW'(set_used));
  assign hit_way    = hit_idx5[WAY_W-1:0];
  assign victim_way = vic_idx5[WAY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_victim <= '0;
    end else begin
      rsp_valid  <= lk_valid;
      rsp_hit    <= lk_valid && any_hit;
      rsp_way    <= any_hit ? hit_way : '0;
      rsp_victim <= any_hit ? '0 : victim_way;
    end
  end

endmodule

// File: rtl/cat_alloc_ctrl_chk.sv
module cat_alloc_ctrl_chk #(
  parameter int NUM_WAYS = 11,
  parameter int WAY_W    = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lk_valid,
  input logic                rsp_valid,
  input logic                rsp_hit,
  input logic [WAY_W-1:0]    rsp_victim,
  input logic [NUM_WAYS-1:0] hit_vec,
  input logic [NUM_WAYS-1:0] lk_mask,
  input logic [NUM_WAYS-1:0] inv_vec,
  input logic                any_mask_zero
);

  logic [NUM_WAYS-1:0] mask_seen, inv_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_seen <= '1;
      inv_seen  <= '0;
    end else if (lk_valid) begin
      mask_seen <= lk_mask;
      inv_seen  <= inv_vec;
    end
  end

  // R11: response one cycle after request
  a_r11_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  // R2: at most one matching way
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0(hit_vec));
  // R3: victim lies inside requester mask
  a_r3_victim_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> ((mask_seen >> rsp_victim) & NUM_WAYS'(1)) != '0);
  // R4: an invalid permitted way is preferred
  a_r4_prefer_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit && inv_seen != '0) |-> ((inv_seen >> rsp_victim) & NUM_WAYS'(1)) != '0);
  // R6: no class mask ever becomes empty
  a_r6_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !any_mask_zero);

endmodule

bind cat_alloc_ctrl cat_alloc_ctrl_chk #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_victim(rsp_victim), .hit_vec(hit_vec),
  .lk_mask(lk_mask), .inv_vec(inv_vec), .any_mask_zero(any_mask_zero)
);

// File: tb/cat_alloc_ctrl_bench.sv
module cat_alloc_ctrl_bench;

  localparam int NW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [NW-1:0] cfg_data = '0;
  logic          lk_valid = 1'b0;
  logic [1:0]    lk_core = '0;
  logic [19:0]   lk_addr = '0;
  logic          rsp_valid, rsp_hit;
  logic [3:0]    rsp_way, rsp_victim;
  logic          fill_valid = 1'b0;
  logic [19:0]   fill_addr = '0;
  logic [3:0]    fill_way = '0;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cat_alloc_ctrl u_cat_alloc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_idx(cfg_idx), .cfg_data(cfg_data), .lk_valid(lk_valid),
    .lk_core(lk_core), .lk_addr(lk_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_victim(rsp_victim),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way)
  );

  // address = {tag[9:0], set[3:0], offset[5:0]}
  function automatic logic [19:0] mk(input int tag, input int set);
    return {10'(tag), 4'(set), 6'h15};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input bit sel, input int idx, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = 4'(idx); cfg_data = NW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic look(input int core, input int tag, input int set,
                      output bit hit, output int way, output int vic);
    @(negedge clk);
    lk_valid = 1'b1; lk_core = 2'(core); lk_addr = mk(tag, set);
    @(negedge clk);
    lk_valid = 1'b0;
    hit = rsp_hit; way = int'(rsp_way); vic = int'(rsp_victim);
    chk(rsp_valid == 1'b1, "R11 rsp_valid", int'(rsp_valid), 1);
  endtask

  task automatic fill(input int tag, input int set, input int way);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = mk(tag, set); fill_way = 4'(way);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic expect_miss(input int core, input int tag, input int set,
                             input int vic_exp, input string req);
    bit h; int w, v;
    look(core, tag, set, h, w, v);
    chk(!h, {req, " miss"}, int'(h), 0);
    chk(v == vic_exp, {req, " victim"}, v, vic_exp);
  endtask

  task automatic expect_hit(input int core, input int tag, input int set,
                            input int way_exp, input string req);
    bit h; int w, v;
    look(core, tag, set, h, w, v);
    chk(h, {req, " hit"}, int'(h), 1);
    chk(w == way_exp, {req, " way"}, w, way_exp);
    chk(v == 0, "R11 victim zero on hit", v, 0);
  endtask

  task automatic t_reset;
    chk(rsp_valid == 1'b0, "R1 idle after reset", int'(rsp_valid), 0);
    for (int c = 0; c < 4; c++) expect_miss(c, 5, 0, 0, "R1 reset");
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 no request no response", int'(rsp_valid), 0);
  endtask

  task automatic t_fill_order;
    // core1 stays in class 0 (all ways). Invalid ways are used lowest first.
    for (int w = 0; w < NW; w++) begin
      expect_miss(1, 16 + w, 2, w, "R4 invalid first");
      fill(16 + w, 2, w);
    end
    // used bits full after way10 -> only way10 kept
    expect_miss(1, 200, 2, 0, "R5 wrap to way0");
    expect_hit(1, 19, 2, 3, "R9 filled tag");
    expect_miss(1, 201, 2, 0, "R5 way0 still cold");
    fill(100, 2, 0);
    expect_miss(1, 202, 2, 1, "R5 after ways 0,3,10 used");
  endtask

  task automatic t_restricted;
    cfg(1'b0, 1, 'h003);
    cfg(1'b1, 0, 1);
    expect_miss(0, 40, 1, 0, "R10 class1 first victim");
    fill(40, 1, 0);
    expect_miss(0, 41, 1, 1, "R3 second permitted way");
    fill(41, 1, 1);
    expect_miss(0, 42, 1, 0, "R5 all permitted used");
    expect_hit(0, 21, 2, 5, "R2 hit outside mask");
    expect_hit(1, 40, 1, 0, "R2 other class hit");
  endtask

  task automatic t_zero_reject;
    cfg(1'b0, 2, 'h00C);
    cfg(1'b1, 2, 2);
    expect_miss(2, 60, 3, 2, "R10 class2 victim");
    cfg(1'b0, 2, 0);
    expect_miss(2, 61, 3, 2, "R6 zero mask rejected");
  endtask

  task automatic t_reconfig;
    cfg(1'b1, 1, 2);
    cfg(1'b0, 0, 'h001);
    expect_hit(1, 23, 2, 7, "R7 line stays after class change");
    expect_hit(3, 41, 1, 1, "R7 line stays after mask change");
    expect_miss(1, 21, 4, 2, "R8 same tag other set");
    expect_miss(3, 21, 4, 0, "R8 class0 now way0 only");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill_order();
    t_restricted();
    t_zero_reject();
    t_reconfig();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule